// File: doc/BRIEF.md
# Tree Reduction Index Scheduler

This block generates the operand index stream for reducing a vector of up to `MAX_N` elements to one value with a binary tree. Each operation combines a left element with a right element and writes the result back into the left element. The block issues one operation per valid cycle. A one-bit selector chooses whether the stream carries the left index or the right index, so two copies of the block can drive the two source ports of a downstream unit. A predicate mask takes elements out of the reduction. The schedule is fully determined by its inputs, so the block reports the operation count in the cycle after the request, before the first index is issued.

Internally the block keeps one slot per element position. With forward inner order, slot s starts on element s. With reversed inner order, slot s starts on element N-1-s. A slot is live when its element is active, meaning its predicate bit is set and its index is below N. The walk visits slot pairs (L, L+d). When both slots are live, an operation is issued and the right slot stops being live. When only the right slot is live, the left slot takes over the right slot's element and no operation is issued. Pairs whose right slot lies at N or beyond are passed over. Each candidate pair takes one cycle. `idx_valid` is high only on cycles that issue an operation. `done` pulses for one cycle after the last candidate.

Top module: `tree_reduce_sched`

## Requirements
- R1: With `pick_right`=0, `idx` shows the left (destination) element of each operation. With `pick_right`=1, `idx` shows the right element. The selection is captured when the request is accepted.
- R2: With `inner_rev`=0, every operation has left < right, and the last operation's left index is the lowest active element.
- R3: With `inner_rev`=1, every operation has left > right, and the last operation's left index is the highest active element.
- R4: With `outer_down`=0, passes use pair distance d = 1, 2, 4, … while d < N. Within a pass, left slots are 0, 2d, 4d, … below N, in increasing order.
- R5: With `outer_down`=1, d starts at the largest power of two below N and halves down to 1. Within a pass, left slots are 0 … d-1, in increasing order. The pair distance is always a power of two, and the left slot stays below N.
- R6: `op_count` equals the number of active elements minus one (0 when there are none). It is valid from the cycle after the request, and exactly that many operations are issued. Because `MAX_N` ≤ 128, the count never exceeds 127.
- R7: Only active elements appear in the stream. An element is a right operand at most once, and no masked or out-of-range element is ever a destination.
- R8: When N ≤ 1, or when at most one element is active, no operation is issued. For N ≤ 1, `done` pulses in the cycle after the request.
- R9: A `start` pulse while `busy` is high is ignored, and the running schedule and `op_count` are unchanged.
- R10: An `elem_cnt` above `MAX_N` is treated as `MAX_N`.
- R11: After reset, `busy`, `idx_valid`, `done` and `op_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a schedule; accepted only when idle |
| elem_cnt | input | CW | Number of elements N |
| inner_rev | input | 1 | Reverse the inner order (result lands in the last active element) |
| outer_down | input | 1 | Pair distance runs downward instead of upward |
| pick_right | input | 1 | Stream the right index instead of the left index |
| pred | input | MAX_N | Per-element predicate mask |
| busy | output | 1 | A schedule is being walked |
| idx_valid | output | 1 | `idx` carries an operation this cycle |
| idx | output | IW | Selected element index |
| done | output | 1 | One-cycle pulse after the schedule ends |
| op_count | output | CW | Number of operations in the schedule |

## Verification
The assertions check on every cycle that operand order agrees with the inner-order setting, and that both operands are active elements. They also check that each issued operation removes exactly one live slot, that the pair distance stays a power of two with the left slot below N, that the issued count matches `op_count` at `done`, and that a `start` pulse while busy leaves the count alone. The bench's scenarios are needed to show the exact stream order for each of the four order combinations. They also show where the final result lands, that masked elements are never written, and the clamp on N. Each configuration runs twice, with `pick_right` at 0 and at 1, and the two streams are paired operation by operation.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rdx_state_e;

    typedef struct packed {
        logic inner_rev;
        logic pick_right;
    } rdx_cfg_t;

    // Largest power of two strictly below n (1 for n <= 2).
    function automatic int top_stride(int n);
        int r;
        r = 1;
        for (int k = 0; k < 16; k++) begin
            if ((r * 2) < n) r = r * 2;
        end
        return r;
    endfunction

endpackage

// File: rtl/rdx_count.sv
module rdx_count #(
    parameter  int MAX_N = 16,
    localparam int CW    = $clog2(MAX_N + 1)
) (
    input  logic [CW-1:0]    n,
    input  logic [MAX_N-1:0] pred,
    output logic [CW-1:0]    ops
);
    logic [CW-1:0] active;

    always_comb begin
        active = '0;
        for (int s = 0; s < MAX_N; s++) begin
            if ((CW'(s) < n) && pred[s]) active = active + CW'(1);
        end
        ops = (active == '0) ? '0 : active - CW'(1);
    end
endmodule

// File: rtl/rdx_walk.sv
module rdx_walk
    import rdx_pkg::*;
#(
    parameter  int MAX_N = 16,
    localparam int CW    = $clog2(MAX_N + 1),
    localparam int PW    = CW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          outer_down,
    input  logic [CW-1:0] n,
    output logic [PW-1:0] lpos,
    output logic [PW-1:0] rpos,
    output logic          fin
);
    logic [PW-1:0] l_q, d_q, n_q;
    logic          down_q;
    logic [PW-1:0] l_try, l_nx, d_nx;
    logic          pass_end;

    always_comb begin
        if (!down_q) begin
            l_try    = l_q + (d_q << 1);
            pass_end = (l_try >= n_q);
            d_nx     = pass_end ? (d_q << 1) : d_q;
            fin      = pass_end && ((d_q << 1) >= n_q);
        end else begin
            l_try    = l_q + PW'(1);
            pass_end = (l_try >= d_q);
            fin      = pass_end && (d_q == PW'(1));
            d_nx     = (pass_end && !fin) ? (d_q >> 1) : d_q;
        end
        l_nx = pass_end ? '0 : l_try;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_q    <= '0;
            d_q    <= PW'(1);
            n_q    <= '0;
            down_q <= 1'b0;
        end else if (load) begin
            l_q    <= '0;
            d_q    <= outer_down ? PW'(top_stride(int'(n))) : PW'(1);
            n_q    <= PW'(n);
            down_q <= outer_down;
        end else if (step) begin
            l_q <= l_nx;
            d_q <= d_nx;
        end
    end

    assign lpos = l_q;
    assign rpos = l_q + d_q;

    a_r5_stride_pow2: assert property (@(posedge clk) disable iff (rst)
        $countones(d_q) == 1);
    a_r4_left_slot_in_range: assert property (@(posedge clk) disable iff (rst)
        step |-> (l_q < n_q));
endmodule

// File: rtl/rdx_slots.sv
module rdx_slots #(
    parameter  int MAX_N = 16,
    localparam int CW    = $clog2(MAX_N + 1),
    localparam int IW    = $clog2(MAX_N),
    localparam int PW    = CW + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             inner_rev,
    input  logic [CW-1:0]    n,
    input  logic [MAX_N-1:0] pred,
    input  logic [PW-1:0]    lpos,
    input  logic [PW-1:0]    rpos,
    output logic [IW-1:0]    lidx,
    output logic [IW-1:0]    ridx,
    output logic             pair
);
    logic [IW-1:0]    hold_q [MAX_N];
    logic [MAX_N-1:0] live_q;
    logic [PW-1:0]    n_q;
    logic [IW-1:0]    init_hold [MAX_N];
    logic [MAX_N-1:0] init_live;
    logic [IW-1:0]    ls, rs;
    logic             in_rng;

    for (genvar s = 0; s < MAX_N; s++) begin : g_init
        logic [CW-1:0] src;
        assign src          = inner_rev ? (n - CW'(s + 1)) : CW'(s);
        assign init_hold[s] = src[IW-1:0];
        assign init_live[s] = (CW'(s) < n) && pred[src[IW-1:0]];
    end

    assign ls     = lpos[IW-1:0];
    assign rs     = rpos[IW-1:0];
    assign in_rng = (rpos < n_q);
    assign pair   = in_rng && live_q[ls] && live_q[rs];
    assign lidx   = hold_q[ls];
    assign ridx   = hold_q[rs];

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            n_q    <= '0;
            for (int s = 0; s < MAX_N; s++) hold_q[s] <= '0;
        end else if (load) begin
            live_q <= init_live;
            n_q    <= PW'(n);
            for (int s = 0; s < MAX_N; s++) hold_q[s] <= init_hold[s];
        end else if (step && in_rng) begin
            if (live_q[ls] && live_q[rs]) begin
                live_q[rs] <= 1'b0;
            end else if (live_q[rs]) begin
                hold_q[ls] <= hold_q[rs];
                live_q[ls] <= 1'b1;
                live_q[rs] <= 1'b0;
            end
        end
    end

    // R7: each issued operation retires exactly one live slot
    a_r7_one_retired: assert property (@(posedge clk) disable iff (rst)
        (step && pair && !load) |=> ($countones(live_q) == $countones($past(live_q)) - 1));
endmodule

// File: rtl/tree_reduce_sched.sv
module tree_reduce_sched
    import rdx_pkg::*;
#(
    parameter  int MAX_N = 16,
    localparam int CW    = $clog2(MAX_N + 1),
    localparam int IW    = $clog2(MAX_N),
    localparam int PW    = CW + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CW-1:0]    elem_cnt,
    input  logic             inner_rev,
    input  logic             outer_down,
    input  logic             pick_right,
    input  logic [MAX_N-1:0] pred,
    output logic             busy,
    output logic             idx_valid,
    output logic [IW-1:0]    idx,
    output logic             done,
    output logic [CW-1:0]    op_count
);
    rdx_state_e       state_q;
    rdx_cfg_t         cfg_q;
    logic [MAX_N-1:0] pred_q;
    logic [CW-1:0]    ops_q, emitted_q, ops_c, n_eff;
    logic             done_q, load, step, fin, pair;
    logic [PW-1:0]    lpos, rpos;
    logic [IW-1:0]    lidx, ridx;

    assign n_eff = (elem_cnt > CW'(MAX_N)) ? CW'(MAX_N) : elem_cnt;
    assign load  = start && (state_q == ST_IDLE);
    assign step  = (state_q == ST_RUN);

    rdx_count #(.MAX_N(MAX_N)) count_i (
        .n(n_eff), .pred(pred), .ops(ops_c)
    );

    rdx_walk #(.MAX_N(MAX_N)) walk_i (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .outer_down(outer_down), .n(n_eff),
        .lpos(lpos), .rpos(rpos), .fin(fin)
    );

    rdx_slots #(.MAX_N(MAX_N)) slots_i (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .inner_rev(inner_rev), .n(n_eff), .pred(pred),
        .lpos(lpos), .rpos(rpos), .lidx(lidx), .ridx(ridx), .pair(pair)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cfg_q     <= '0;
            pred_q    <= '0;
            ops_q     <= '0;
            emitted_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                cfg_q     <= '{inner_rev: inner_rev, pick_right: pick_right};
                pred_q    <= pred;
                ops_q     <= ops_c;
                emitted_q <= '0;
                if (n_eff <= CW'(1)) done_q  <= 1'b1;
                else                 state_q <= ST_RUN;
            end else if (state_q == ST_RUN) begin
                if (pair) emitted_q <= emitted_q + CW'(1);
                if (fin) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign busy      = (state_q == ST_RUN);
    assign idx_valid = busy && pair;
    assign idx       = cfg_q.pick_right ? ridx : lidx;
    assign done      = done_q;
    assign op_count  = ops_q;

    a_r2_fwd_order: assert property (@(posedge clk) disable iff (rst)
        (idx_valid && !cfg_q.inner_rev) |-> (lidx < ridx));
    a_r3_rev_order: assert property (@(posedge clk) disable iff (rst)
        (idx_valid && cfg_q.inner_rev) |-> (lidx > ridx));
    a_r7_operands_active: assert property (@(posedge clk) disable iff (rst)
        idx_valid |-> (pred_q[lidx] && pred_q[ridx]));
    a_r6_count_match: assert property (@(posedge clk) disable iff (rst)
        done |-> (emitted_q == ops_q));
    a_r8_short_done: assert property (@(posedge clk) disable iff (rst)
        (load && (n_eff <= CW'(1))) |=> (done && !busy));
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(ops_q));
endmodule

// File: tb/tree_reduce_sched_tb_top.sv
module tree_reduce_sched_tb_top;
    localparam int MAXN = 16;
    localparam int CW   = 5;
    localparam int IW   = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst, start, inner_rev, outer_down, pick_right;
    logic [CW-1:0]   elem_cnt;
    logic [MAXN-1:0] pred;
    logic            busy, idx_valid, done;
    logic [IW-1:0]   idx;
    logic [CW-1:0]   op_count;

    tree_reduce_sched #(.MAX_N(MAXN)) dut_i (
        .clk(clk), .rst(rst), .start(start), .elem_cnt(elem_cnt),
        .inner_rev(inner_rev), .outer_down(outer_down), .pick_right(pick_right),
        .pred(pred), .busy(busy), .idx_valid(idx_valid), .idx(idx),
        .done(done), .op_count(op_count)
    );

    int checks = 0;
    int bad    = 0;
    int cyc    = 0;
    int exp_l[$], exp_r[$], got[$], got_l[$], got_r[$];
    int m_hold[MAXN];
    bit m_live[MAXN];

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic void model_merge(int a, int b, int nn);
        if (b < nn) begin
            if (m_live[a] && m_live[b]) begin
                exp_l.push_back(m_hold[a]);
                exp_r.push_back(m_hold[b]);
                m_live[b] = 0;
            end else if (m_live[b]) begin
                m_hold[a] = m_hold[b];
                m_live[a] = 1;
                m_live[b] = 0;
            end
        end
    endfunction

    function automatic void build_model(int nn, bit ii, bit io, logic [MAXN-1:0] pm);
        int d;
        exp_l.delete();
        exp_r.delete();
        for (int s = 0; s < MAXN; s++) begin
            m_live[s] = 0;
            m_hold[s] = 0;
        end
        for (int s = 0; s < nn; s++) begin
            m_hold[s] = ii ? nn - 1 - s : s;
            m_live[s] = pm[m_hold[s]];
        end
        if (nn > 1) begin
            if (!io) begin
                for (d = 1; d < nn; d = d * 2)
                    for (int a = 0; a < nn; a += 2 * d) model_merge(a, a + d, nn);
            end else begin
                d = 1;
                while (d * 2 < nn) d = d * 2;
                for (; d >= 1; d = d / 2)
                    for (int a = 0; a < d; a++) model_merge(a, a + d, nn);
            end
        end
    endfunction

    task automatic run_once(input int nn, input bit ii, input bit io, input bit sr,
                            input logic [MAXN-1:0] pm, input bit poke, input int exp_ops);
        int waited;
        got.delete();
        @(negedge clk);
        start = 1'b1; elem_cnt = CW'(nn); inner_rev = ii; outer_down = io;
        pick_right = sr; pred = pm;
        @(negedge clk);
        start = 1'b0;
        chk(op_count == CW'(exp_ops), "R6 op_count", op_count, exp_ops);
        waited = 0;
        while (!done && waited < 400) begin
            if (idx_valid) got.push_back(int'(idx));
            if (poke && waited == 1) begin
                start = 1'b1; elem_cnt = 3; pred = '1; inner_rev = ~ii; pick_right = ~sr;
            end else begin
                start = 1'b0; elem_cnt = CW'(nn); pred = pm; inner_rev = ii; pick_right = sr;
            end
            @(negedge clk);
            waited++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R8 done pulse seen", done, 1);
        chk(!busy && !idx_valid, "R8 idle after done", busy, 0);
    endtask

    task automatic run_case(input string tag, input int nn, input bit ii, input bit io,
                            input logic [MAXN-1:0] pm, input bit poke);
        int ne, act, first_a, last_a, seen_r[MAXN];
        ne = (nn > MAXN) ? MAXN : nn;
        act = 0; first_a = -1; last_a = -1;
        for (int e = 0; e < ne; e++) if (pm[e]) begin
            act++;
            if (first_a < 0) first_a = e;
            last_a = e;
        end
        build_model(ne, ii, io, pm);
        run_once(nn, ii, io, 1'b0, pm, poke, (act > 0) ? act - 1 : 0);
        got_l = got;
        run_once(nn, ii, io, 1'b1, pm, poke, (act > 0) ? act - 1 : 0);
        got_r = got;
        // R1 / R4 / R5 / R9: full stream order against the model
        chk(got_l.size() == exp_l.size(), {tag, " R1 left count"}, got_l.size(), exp_l.size());
        chk(got_r.size() == exp_r.size(), {tag, " R1 right count"}, got_r.size(), exp_r.size());
        chk(got_l.size() == ((act > 0) ? act - 1 : 0), {tag, " R6 ops issued"}, got_l.size(), act - 1);
        for (int k = 0; k < exp_l.size() && k < got_l.size() && k < got_r.size(); k++) begin
            chk(got_l[k] == exp_l[k], {tag, " R4/R5 left order"}, got_l[k], exp_l[k]);
            chk(got_r[k] == exp_r[k], {tag, " R4/R5 right order"}, got_r[k], exp_r[k]);
            if (ii) chk(got_l[k] > got_r[k], {tag, " R3 left>right"}, got_l[k], got_r[k]);
            else    chk(got_l[k] < got_r[k], {tag, " R2 left<right"}, got_l[k], got_r[k]);
        end
        for (int e = 0; e < MAXN; e++) seen_r[e] = 0;
        for (int k = 0; k < got_l.size() && k < got_r.size(); k++) begin
            chk(got_l[k] < ne && pm[got_l[k]], {tag, " R7 dest active"}, got_l[k], 1);
            chk(got_r[k] < ne && pm[got_r[k]], {tag, " R7 src active"}, got_r[k], 1);
            seen_r[got_r[k]]++;
            chk(seen_r[got_r[k]] == 1, {tag, " R7 right used once"}, seen_r[got_r[k]], 1);
        end
        if (act >= 2 && got_l.size() > 0) begin
            if (ii) chk(got_l[got_l.size()-1] == last_a, {tag, " R3 result in last active"},
                        got_l[got_l.size()-1], last_a);
            else    chk(got_l[got_l.size()-1] == first_a, {tag, " R2 result in first active"},
                        got_l[got_l.size()-1], first_a);
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; elem_cnt = '0; inner_rev = 1'b0;
        outer_down = 1'b0; pick_right = 1'b0; pred = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(!busy && !idx_valid && !done, "R11 reset flags", {busy, idx_valid, done}, 0);
        chk(op_count == '0, "R11 reset op_count", op_count, 0);

        run_case("full8 up fwd",   8,  1'b0, 1'b0, 16'h00FF, 1'b0);
        run_case("full8 up rev",   8,  1'b1, 1'b0, 16'h00FF, 1'b0);
        run_case("n6 down fwd",    6,  1'b0, 1'b1, 16'h003F, 1'b0);
        run_case("sparse7 down rev", 7, 1'b1, 1'b1, 16'h0052, 1'b0);
        run_case("sparse13 up rev", 13, 1'b1, 1'b0, 16'h1B6A, 1'b0);
        run_case("n3 down fwd",    3,  1'b0, 1'b1, 16'h0007, 1'b0);
        run_case("R9 poke n16",    16, 1'b0, 1'b0, 16'hA5C3, 1'b1);
        run_case("R8 single bit",  5,  1'b0, 1'b0, 16'h0004, 1'b0);
        run_case("R8 no active",   8,  1'b1, 1'b1, 16'h0000, 1'b0);
        run_case("R8 n1",          1,  1'b0, 1'b0, 16'hFFFF, 1'b0);
        run_case("R8 n0",          0,  1'b1, 1'b0, 16'hFFFF, 1'b0);
        run_case("R7 mask beyond n", 4, 1'b0, 1'b1, 16'hFFF5, 1'b0);
        run_case("n2 fwd",         2,  1'b0, 1'b0, 16'h0003, 1'b0);
        run_case("R10 clamp 20",   20, 1'b1, 1'b1, 16'hFFFF, 1'b0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule